// File: doc/BRIEF.md
# Configuration Register File with Command Register

This block holds a 256-entry by 8-bit configuration memory. Two write sources reach it. A byte-write port stands in for a serial slave interface and is driven by a write strobe with an address and data. A bulk-load port fills the memory at boot. A read port returns any entry after a fixed two-cycle latency.

Only the addresses named in a supported-address mask store data. Every other address below the top one is wired to its default value.

The top address holds a command register with three control bits:
- **Attach (bit 0).** Raises an attach output and write-protects the rest of the file against the serial port.
- **Soft reset (bit 1).** Returns the whole file, command register included, to its power-on defaults.
- **Power-down request (bit 2).** Arms an interface power-down flag. The flag rises on the next transfer-acknowledge pulse.

Top module: `cfg_rf_top`

## Requirements
- R1: After the synchronous reset, `attach` and `pwr_down` are 0. Every address below 0xFF reads its default: (address XOR `DFLT_XOR`) for supported addresses and 0x00 for unsupported ones.
- R2: `rd_data` shows the contents of the address presented on `rd_addr` exactly two rising edges later.
- R3: A write through either port to a supported address below 0xFF is stored and reads back unchanged.
- R4: A write to an unsupported address below 0xFF is dropped, and that address keeps reading its default of 0x00.
- R5: Address 0xFF reads {5'b0, power-down request, 1'b0, attach}. Reserved bits 7:3 and the reset bit always read 0.
- R6: Writing 0xFF with bit 0 = 1 raises `attach` one edge later. While `attach` is 1, serial-port writes to 0x00..0xFE are ignored and the load port still writes.
- R7: While attached, 0xFF stays writable from the serial port. Writing bit 0 = 0 drops `attach`, and serial writes are accepted again.
- R8: Writing 0xFF with bit 1 = 1 (other bits ignored) is followed one edge later by a return of every address, `attach`, `pwr_down` and the power-down request to their defaults. Writes presented in that cycle are dropped.
- R9: Writing 0xFF with bit 2 = 1 does not raise `pwr_down` by itself. The flag rises at the edge of the first `xfer_ack` pulse that comes after the write edge. An acknowledge in the same cycle as the write does not count. Writing bit 2 = 0 clears both the request and `pwr_down`.
- R10: If both `sw_we` and `ld_we` are high in one cycle, only the serial-port write is considered. The load write is dropped, even when protection then blocks the serial write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Serial-port write strobe |
| sw_addr | input | 8 | Serial-port write address |
| sw_wdata | input | 8 | Serial-port write data |
| xfer_ack | input | 1 | Pulse marking that a transfer's acknowledge completed |
| ld_we | input | 1 | Bulk-load write strobe |
| ld_addr | input | 8 | Bulk-load address |
| ld_wdata | input | 8 | Bulk-load data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, two cycles after `rd_addr` |
| attach | output | 1 | Attach indication (command bit 0) |
| pwr_down | output | 1 | Interface power-down flag |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data, `DFLT_XOR` = 0xA5 and a mask that keeps addresses 0x00–0x3F and 0x80–0x9F.

This mask leaves two holes, at 0x40–0x7F and 0xA0–0xFE. Random writes therefore land on supported addresses, on unsupported addresses and on the command register. Because the supported defaults are non-zero, a soft reset that forgot an entry or a read that ignored the mask would show a wrong value.

// File: rtl/cfg_rf_pkg.sv
package cfg_rf_pkg;
  localparam int unsigned CMD_ATTACH = 0;
  localparam int unsigned CMD_SRST   = 1;
  localparam int unsigned CMD_PDOWN  = 2;

  // Power-on value of one entry: supported entries take addr ^ xor_pat, others zero
  function automatic logic [63:0] rf_default(input logic kept, input int unsigned a,
                                             input logic [63:0] xor_pat);
    return kept ? (64'(a) ^ xor_pat) : 64'd0;
  endfunction
endpackage

// File: rtl/cfg_wr_arb.sv
module cfg_wr_arb #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [(2**AW)-1:0] KEEP_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic          protect,
  input  logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cmd_we,
  output logic [2:0]    cmd_bits
);
  localparam int unsigned DEPTH = 2**AW;
  localparam logic [AW-1:0] TOP_A = AW'(DEPTH-1);

  logic req;
  logic at_top;

  always_comb begin
    req       = sw_we | ld_we;
    mem_addr  = sw_we ? sw_addr  : ld_addr;
    mem_wdata = sw_we ? sw_wdata : ld_wdata;
    at_top    = (mem_addr == TOP_A);
    cmd_bits  = mem_wdata[2:0];
    cmd_we    = req && !busy && at_top;
    mem_we    = req && !busy && !at_top && KEEP_MASK[mem_addr] && !(sw_we && protect);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && cmd_we)); // R10
  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (protect && sw_we) |-> !mem_we); // R6
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!mem_we && !cmd_we)); // R8
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [(2**AW)-1:0] KEEP_MASK = '0,
  parameter logic [DW-1:0] DFLT_XOR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] cmd_val,
  output logic [DW-1:0] rd_data
);
  import cfg_rf_pkg::*;
  localparam int unsigned DEPTH = 2**AW;
  localparam logic [AW-1:0] TOP_A = AW'(DEPTH-1);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    ram_q;
  logic [DW-1:0]    cmd_q;
  logic [AW-1:0]    raddr_q;
  logic             vld_q;
  logic [DW-1:0]    dflt_q;

  // Plain RAM: no reset, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ram_q <= mem[raddr];
  end

  // Written-flags make the RAM contents visible; clearing them restores defaults
  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raddr_q <= '0;
      vld_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      raddr_q <= raddr;
      vld_q   <= vld[raddr];
      cmd_q   <= cmd_val;
    end
  end

  always_comb dflt_q = DW'(rf_default(KEEP_MASK[raddr_q], int'(raddr_q), 64'(DFLT_XOR)));

  always_ff @(posedge clk) begin
    if (rst)                   rd_data <= '0;
    else if (raddr_q == TOP_A) rd_data <= cmd_q;
    else if (vld_q)            rd_data <= ram_q;
    else                       rd_data <= dflt_q;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld == '0)); // R8
  AST_ONLY_KEPT: assert property (@(posedge clk) disable iff (rst)
    we |-> (KEEP_MASK[waddr] && waddr != TOP_A)); // R4
  AST_TOP_RSVD: assert property (@(posedge clk) disable iff (rst)
    (raddr_q == TOP_A) |=> (rd_data[DW-1:3] == '0 && rd_data[1] == 1'b0)); // R5
endmodule

// File: rtl/cfg_cmd.sv
module cfg_cmd #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [2:0]    cmd_bits,
  input  logic          xfer_ack,
  output logic          attach,
  output logic          pwr_down,
  output logic          busy,
  output logic [DW-1:0] cmd_val
);
  import cfg_rf_pkg::*;
  logic pd_req;

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      attach   <= 1'b0;
      pd_req   <= 1'b0;
      pwr_down <= 1'b0;
      busy     <= 1'b0;
    end else if (cmd_we) begin
      if (cmd_bits[CMD_SRST]) begin
        busy <= 1'b1;
      end else begin
        attach <= cmd_bits[CMD_ATTACH];
        pd_req <= cmd_bits[CMD_PDOWN];
        if (!cmd_bits[CMD_PDOWN]) pwr_down <= 1'b0;
      end
    end else if (xfer_ack && pd_req) begin
      pwr_down <= 1'b1;
    end
  end

  always_comb begin
    cmd_val = '0;
    cmd_val[CMD_ATTACH] = attach;
    cmd_val[CMD_PDOWN]  = pd_req;
  end

  AST_PD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> ($past(xfer_ack) && $past(pd_req))); // R9
  AST_SRST_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && !attach && !pwr_down)); // R8
  AST_ATTACH_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(attach) |-> $past(cmd_we)); // R6
endmodule

// File: rtl/cfg_rf_top.sv
module cfg_rf_top #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [(2**AW)-1:0] KEEP_MASK =
    256'h0000_0000_0000_0000_0000_0000_FFFF_FFFF_0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
  parameter logic [DW-1:0] DFLT_XOR = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          xfer_ack,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          attach,
  output logic          pwr_down
);
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          cmd_we;
  logic [2:0]    cmd_bits;
  logic          busy;
  logic [DW-1:0] cmd_val;

  cfg_wr_arb #(.AW(AW), .DW(DW), .KEEP_MASK(KEEP_MASK)) u_arb (
    .clk(clk), .rst(rst),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
    .protect(attach), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmd_we(cmd_we), .cmd_bits(cmd_bits)
  );

  cfg_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_bits(cmd_bits),
    .xfer_ack(xfer_ack), .attach(attach), .pwr_down(pwr_down),
    .busy(busy), .cmd_val(cmd_val)
  );

  cfg_store #(.AW(AW), .DW(DW), .KEEP_MASK(KEEP_MASK), .DFLT_XOR(DFLT_XOR)) u_store (
    .clk(clk), .rst(rst), .clr(busy),
    .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .cmd_val(cmd_val), .rd_data(rd_data)
  );

  AST_LOAD_IGNORES_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (ld_we && !sw_we && !busy && ld_addr != AW'((2**AW)-1) && KEEP_MASK[ld_addr]) |-> mem_we); // R6
endmodule

// File: tb/cfg_rf_top_tb_top.sv
`timescale 1ns/1ps
module cfg_rf_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sw_we, ld_we, xfer_ack;
  logic [7:0] sw_addr, sw_wdata, ld_addr, ld_wdata, rd_addr;
  logic [7:0] rd_data;
  logic       attach, pwr_down;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_mem [256];
  logic m_att, m_pd, m_pwr, m_busy;

  always #2 clk = ~clk;

  cfg_rf_top dut_i (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .xfer_ack(xfer_ack), .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .attach(attach), .pwr_down(pwr_down)
  );

  function automatic bit kept(input logic [7:0] a);
    return (a < 8'h40) || (a >= 8'h80 && a < 8'hA0);
  endfunction

  function automatic logic [7:0] dflt(input logic [7:0] a);
    return kept(a) ? (a ^ 8'hA5) : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = dflt(8'(i));
    m_att = 0; m_pd = 0; m_pwr = 0; m_busy = 0;
  endtask

  // One clock: drive at negedge, update model for the coming edge, land on next negedge
  task automatic step(input bit swe, input logic [7:0] sa, input logic [7:0] sd,
                      input bit lwe, input logic [7:0] la, input logic [7:0] ldd,
                      input bit ack);
    logic [7:0] a, d;
    bit from_sw, cmdw;
    sw_we = swe; sw_addr = sa; sw_wdata = sd;
    ld_we = lwe; ld_addr = la; ld_wdata = ldd; xfer_ack = ack;
    cmdw = 0;
    if (m_busy) begin
      model_reset();
    end else if (swe || lwe) begin
      from_sw = swe;
      a = swe ? sa : la;
      d = swe ? sd : ldd;
      if (a == 8'hFF) begin
        cmdw = 1;
        if (d[1]) m_busy = 1;
        else begin
          m_att = d[0]; m_pd = d[2];
          if (!d[2]) m_pwr = 0;
        end
      end else if (kept(a) && !(from_sw && m_att)) begin
        m_mem[a] = d;
      end
    end
    if (!m_busy && !cmdw && ack && m_pd) m_pwr = 1;
    @(negedge clk);
    sw_we = 0; ld_we = 0; xfer_ack = 0;
    chk("R6 attach", {7'd0, attach}, {7'd0, m_att});
    chk("R9 pwr_down", {7'd0, pwr_down}, {7'd0, m_pwr});
    if (m_busy) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic swr(input logic [7:0] a, input logic [7:0] d); step(1, a, d, 0, 0, 0, 0); endtask
  task automatic ldw(input logic [7:0] a, input logic [7:0] d); step(0, 0, 0, 1, a, d, 0); endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [7:0] e;
    rd_addr = a;
    idle();
    idle();
    e = (a == 8'hFF) ? {5'd0, m_pd, 1'b0, m_att} : m_mem[a];
    chk(req, rd_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    sw_we = 0; ld_we = 0; xfer_ack = 0;
    sw_addr = 0; sw_wdata = 0; ld_addr = 0; ld_wdata = 0; rd_addr = 0;
    rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 attach", {7'd0, attach}, 8'd0);
    chk("R1 pwr_down", {7'd0, pwr_down}, 8'd0);
    rd_chk("R1 default kept", 8'h05);
    rd_chk("R1 default kept hi", 8'h9F);
    rd_chk("R1 default hole", 8'h50);
    rd_chk("R1 R5 cmd reset", 8'hFF);
    // R2 R3 both ports
    swr(8'h10, 8'h3C); rd_chk("R2 R3 serial write", 8'h10);
    ldw(8'h85, 8'hC3); rd_chk("R3 load write", 8'h85);
    // R4 unsupported
    swr(8'h60, 8'h77); rd_chk("R4 hole serial", 8'h60);
    ldw(8'hC0, 8'h11); rd_chk("R4 hole load", 8'hC0);
    // R5 reserved bits
    swr(8'hFF, 8'hF8); rd_chk("R5 reserved zero", 8'hFF);
    swr(8'hFF, 8'h00);
    // R6 attach and protection
    swr(8'hFF, 8'h01);
    chk("R6 attach up", {7'd0, attach}, 8'd1);
    swr(8'h11, 8'hAA); rd_chk("R6 serial blocked", 8'h11);
    ldw(8'h12, 8'h5B); rd_chk("R6 load allowed", 8'h12);
    rd_chk("R5 R6 cmd readback", 8'hFF);
    // R10 collision while attached: load dropped as well
    step(1, 8'h13, 8'h01, 1, 8'h14, 8'h02, 0);
    rd_chk("R10 load dropped", 8'h14);
    rd_chk("R6 serial blocked 2", 8'h13);
    // R7 clear attach
    swr(8'hFF, 8'h00);
    swr(8'h11, 8'hAA); rd_chk("R7 writes resume", 8'h11);
    // R10 collision unprotected
    step(1, 8'h20, 8'h9E, 1, 8'h21, 8'h9F, 0);
    rd_chk("R10 serial wins", 8'h20);
    rd_chk("R10 load lost", 8'h21);
    // R9 power-down
    step(1, 8'hFF, 8'h04, 0, 0, 0, 1);
    chk("R9 same-cycle ack ignored", {7'd0, pwr_down}, 8'd0);
    idle();
    chk("R9 no ack no flag", {7'd0, pwr_down}, 8'd0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 ack raises", {7'd0, pwr_down}, 8'd1);
    swr(8'hFF, 8'h00);
    chk("R9 cleared", {7'd0, pwr_down}, 8'd0);
    // R8 soft reset
    swr(8'hFF, 8'h05);
    step(0, 0, 0, 0, 0, 0, 1);
    swr(8'h22, 8'h44);
    sw_we = 1; sw_addr = 8'hFF; sw_wdata = 8'h07;
    @(negedge clk);
    sw_addr = 8'h23; sw_wdata = 8'h66;
    @(negedge clk);
    sw_we = 0;
    model_reset();
    chk("R8 attach cleared", {7'd0, attach}, 8'd0);
    chk("R8 pwr_down cleared", {7'd0, pwr_down}, 8'd0);
    rd_chk("R8 entry restored", 8'h22);
    rd_chk("R8 write in busy dropped", 8'h23);
    rd_chk("R8 earlier entry restored", 8'h10);
    rd_chk("R8 cmd restored", 8'hFF);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic [7:0] a1, a2, d1, d2;
      op = $urandom % 10;
      a1 = 8'($urandom); a2 = 8'($urandom);
      d1 = 8'($urandom); d2 = 8'($urandom);
      if ($urandom % 6 == 0) a1 = 8'hFF;
      if (a1 == 8'hFF && ($urandom % 10 != 0)) d1[1] = 1'b0;
      if (a2 == 8'hFF) d2[1] = 1'b0;
      case (op)
        0, 1, 2: step(1, a1, d1, 0, 0, 0, 1'($urandom));
        3, 4:    step(0, 0, 0, 1, a2, d2, 1'($urandom));
        5:       step(1, a1, d1, 1, a2, d2, 1'($urandom));
        6:       step(0, 0, 0, 0, 0, 0, 1);
        default: rd_chk("R2 R3 R4 random read", 8'($urandom));
      endcase
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule